// File: doc/BRIEF.md
# 2x2 Sliding-Window Reuse Buffer

This block sits between a single-port pixel memory and a compute datapath. It walks a 2x2 window across an image, row by row and left to right. Each window step moves one column to the right, so the right-hand column of one window becomes the left-hand column of the next. The block keeps that column and fetches only the two new pixels for each step. When a window is complete, the block presents all four pixels, a valid strobe and the window's top-left coordinate to the datapath on its own initiative. The datapath never addresses memory.

A frame begins with a start pulse that carries the image width and height, both at least 2. At the beginning of each window row the block reads a full first window, which is two columns of two pixels. After that it reads one column per window. When the datapath accepts every window without waiting, the block issues one read per cycle and emits one window every two cycles. When the datapath holds off, the block keeps the presented window steady and stops reading once its internal column slot and its output slot are both committed. The done output rises once the last window of the frame has been accepted.

Top module: `swin_reuse_buf`

## Requirements
- R1: After reset, `win_valid`, `mem_req` and `done` are all low.
- R2: Pixel (row r, column c) lives at address r*W + c, where W is the width latched at start. Read data is expected on `mem_rdata` one cycle after the `mem_req` cycle. Every address issued is below W*H.
- R3: A window with coordinate (x, y) carries `win_tl` = pixel(y, x), `win_tr` = pixel(y, x+1), `win_bl` = pixel(y+1, x) and `win_br` = pixel(y+1, x+1). Its `win_x` ≤ W-2 and its `win_y` ≤ H-2.
- R4: Windows come out in row-major order: x runs from 0 to W-2 inside each y, and y runs from 0 to H-2. Each window is presented exactly once.
- R5: A frame issues exactly 2*W*(H-1) reads, which is two per window row per image column. No pixel is read twice within a window row.
- R6: A column is fetched as its upper pixel and then, in the next cycle, its lower pixel at an address W higher. The first window of a row appears only after the four reads of that row's first two columns.
- R7: While `win_ready` stays high, consecutive windows within a row are accepted exactly two cycles apart.
- R8: While `win_valid` is high and `win_ready` is low, the window pixels and coordinates hold their values, and `win_valid` stays high.
- R9: While the datapath holds off, reads stop after a bounded number, at most eight, and the block's internal column slot never overflows.
- R10: `done` rises in the cycle after the last window is accepted and stays high until the next accepted start. No read is issued while the block is idle.
- R11: A start pulse during a running frame is ignored. The frame in progress continues with its original dimensions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame; acted on only when idle |
| img_w | input | DIM_W | Image width in pixels (at least 2), latched at start |
| img_h | input | DIM_W | Image height in pixels (at least 2), latched at start |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 16 | Read data, valid one cycle after the request |
| win_valid | output | 1 | Window presented |
| win_ready | input | 1 | Datapath accepts the presented window |
| win_tl | output | 16 | Upper-left pixel |
| win_tr | output | 16 | Upper-right pixel |
| win_bl | output | 16 | Lower-left pixel |
| win_br | output | 16 | Lower-right pixel |
| win_x | output | DIM_W | Window left column |
| win_y | output | DIM_W | Window upper row |
| done | output | 1 | Frame complete, held until the next start |

## Verification
The bench builds the block with DIM_W = 6 and ADDR_W = 12. That keeps every frame small, so whole frames can be compared pixel by pixel against a reference memory. The frame shapes run from the 2x2 minimum, which has a single window, up to 7 columns. They include frames where the first column of a row follows directly on the last column of the row before. Runs with the ready input always high expose the exact two-cycle window spacing. A pseudo-random ready pattern, and a long initial hold-off, push the block against its read throttle and its hold behaviour. A start pulse issued in the middle of one frame checks that the frame keeps its original dimensions.

// File: rtl/swin_pkg.sv
package swin_pkg;

    localparam int PIX_W = 16;

    typedef logic [PIX_W-1:0] pix_t;

    // one image column of the window: upper and lower pixel
    typedef struct packed {
        pix_t top;
        pix_t bot;
    } column_t;

    // full 2x2 window as pushed to the datapath
    typedef struct packed {
        pix_t tl;
        pix_t tr;
        pix_t bl;
        pix_t br;
    } window_t;

    // A new column may be requested only when at most one of the three
    // places that can hold a finished column is committed: the lower read
    // returning this cycle, the pending column slot, and a stalled output.
    function automatic logic credit_ok(input logic tail_returning,
                                       input logic slot_held,
                                       input logic out_stalled);
        logic [1:0] used;
        used = 2'(tail_returning) + 2'(slot_held) + 2'(out_stalled);
        return used <= 2'd1;
    endfunction

endpackage

// File: rtl/swin_fetch.sv
module swin_fetch import swin_pkg::*; #(
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DIM_W-1:0]  w_q,
    input  logic [DIM_W-1:0]  h_q,
    input  logic              credit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_valid,
    output logic              rd_bot,
    output logic [DIM_W-1:0]  rd_x,
    output logic [DIM_W-1:0]  rd_y
);

    logic              busy;
    logic              bot_next;
    logic [DIM_W-1:0]  fx;
    logic [DIM_W-1:0]  fy;
    logic [ADDR_W-1:0] row_base;
    logic              issue_top;
    logic              issue_bot;
    logic              col_end;
    logic              row_end;

    assign issue_top = busy && !bot_next && credit;
    assign issue_bot = bot_next;
    assign col_end   = (fx == w_q - DIM_W'(1));
    assign row_end   = (fy == h_q - DIM_W'(2));

    assign mem_req  = issue_top || issue_bot;
    assign mem_addr = row_base + ADDR_W'(fx) + (bot_next ? ADDR_W'(w_q) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            bot_next <= 1'b0;
            fx       <= '0;
            fy       <= '0;
            row_base <= '0;
            rd_valid <= 1'b0;
            rd_bot   <= 1'b0;
            rd_x     <= '0;
            rd_y     <= '0;
        end else begin
            rd_valid <= mem_req;
            rd_bot   <= issue_bot;
            rd_x     <= fx;
            rd_y     <= fy;
            if (go) begin
                busy     <= 1'b1;
                bot_next <= 1'b0;
                fx       <= '0;
                fy       <= '0;
                row_base <= '0;
            end else if (issue_top) begin
                bot_next <= 1'b1;
            end else if (issue_bot) begin
                bot_next <= 1'b0;
                if (col_end) begin
                    fx <= '0;
                    if (row_end) begin
                        busy <= 1'b0;
                    end else begin
                        fy       <= fy + DIM_W'(1);
                        row_base <= row_base + ADDR_W'(w_q);
                    end
                end else begin
                    fx <= fx + DIM_W'(1);
                end
            end
        end
    end

    // R6: an upper read is always followed by the lower read one row down
    assert_column_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !rd_valid) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(w_q)));

endmodule

// File: rtl/swin_colasm.sv
module swin_colasm import swin_pkg::*; #(
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_valid,
    input  logic             rd_bot,
    input  logic [DIM_W-1:0] rd_x,
    input  logic [DIM_W-1:0] rd_y,
    input  pix_t             rd_data,
    input  logic [DIM_W-1:0] x_last,
    input  logic [DIM_W-1:0] y_last,
    input  logic             take,
    output logic             col_full,
    output column_t          col,
    output logic [DIM_W-1:0] col_x,
    output logic [DIM_W-1:0] col_y,
    output logic             col_first,
    output logic             col_last
);

    pix_t top_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_hold  <= '0;
            col_full  <= 1'b0;
            col       <= '0;
            col_x     <= '0;
            col_y     <= '0;
            col_first <= 1'b0;
            col_last  <= 1'b0;
        end else begin
            if (rd_valid && !rd_bot) begin
                top_hold <= rd_data;
            end
            if (rd_valid && rd_bot) begin
                col       <= '{top: top_hold, bot: rd_data};
                col_x     <= rd_x;
                col_y     <= rd_y;
                col_first <= (rd_x == '0);
                col_last  <= (rd_x == x_last) && (rd_y == y_last);
                col_full  <= 1'b1;
            end else if (take) begin
                col_full <= 1'b0;
            end
        end
    end

    // R9: a completed column never lands on an occupied, unreleased slot
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_bot) |-> (!col_full || take));

endmodule

// File: rtl/swin_winout.sv
module swin_winout import swin_pkg::*; #(
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             col_full,
    input  column_t          col,
    input  logic [DIM_W-1:0] col_x,
    input  logic [DIM_W-1:0] col_y,
    input  logic             col_first,
    input  logic             col_last,
    output logic             take,
    input  logic             win_ready,
    output logic             win_valid,
    output window_t          win_px,
    output logic [DIM_W-1:0] win_x,
    output logic [DIM_W-1:0] win_y,
    output logic             last_accept
);

    column_t left_col;
    logic    win_last;

    assign take        = col_full && (col_first || !win_valid || win_ready);
    assign last_accept = win_valid && win_ready && win_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_col  <= '0;
            win_valid <= 1'b0;
            win_px    <= '0;
            win_x     <= '0;
            win_y     <= '0;
            win_last  <= 1'b0;
        end else begin
            if (win_valid && win_ready) begin
                win_valid <= 1'b0;
            end
            if (take) begin
                left_col <= col;
                if (!col_first) begin
                    win_valid <= 1'b1;
                    win_px    <= '{tl: left_col.top, tr: col.top,
                                   bl: left_col.bot, br: col.bot};
                    win_x     <= col_x - DIM_W'(1);
                    win_y     <= col_y;
                    win_last  <= col_last;
                end
            end
        end
    end

    // R8: a held window keeps its pixels, position and strobe
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !win_ready) |=> (win_valid && $stable(win_px) && $stable(win_x) && $stable(win_y)));

endmodule

// File: rtl/swin_reuse_buf.sv
module swin_reuse_buf import swin_pkg::*; #(
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  img_w,
    input  logic [DIM_W-1:0]  img_h,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              win_valid,
    input  logic              win_ready,
    output logic [PIX_W-1:0]  win_tl,
    output logic [PIX_W-1:0]  win_tr,
    output logic [PIX_W-1:0]  win_bl,
    output logic [PIX_W-1:0]  win_br,
    output logic [DIM_W-1:0]  win_x,
    output logic [DIM_W-1:0]  win_y,
    output logic              done
);

    logic             running;
    logic             go;
    logic [DIM_W-1:0] w_q;
    logic [DIM_W-1:0] h_q;
    logic             credit;
    logic             rd_valid;
    logic             rd_bot;
    logic [DIM_W-1:0] rd_x;
    logic [DIM_W-1:0] rd_y;
    logic             take;
    logic             col_full;
    column_t          col;
    logic [DIM_W-1:0] col_x;
    logic [DIM_W-1:0] col_y;
    logic             col_first;
    logic             col_last;
    window_t          win_px;
    logic             last_accept;

    assign go     = start && !running;
    assign credit = credit_ok(rd_valid && rd_bot, col_full, win_valid && !win_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            done    <= 1'b0;
            w_q     <= DIM_W'(2);
            h_q     <= DIM_W'(2);
        end else if (go) begin
            running <= 1'b1;
            done    <= 1'b0;
            w_q     <= img_w;
            h_q     <= img_h;
        end else if (last_accept) begin
            running <= 1'b0;
            done    <= 1'b1;
        end
    end

    swin_fetch #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .w_q      (w_q),
        .h_q      (h_q),
        .credit   (credit),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .rd_valid (rd_valid),
        .rd_bot   (rd_bot),
        .rd_x     (rd_x),
        .rd_y     (rd_y)
    );

    swin_colasm #(.DIM_W(DIM_W)) u_colasm (
        .clk       (clk),
        .rst       (rst),
        .rd_valid  (rd_valid),
        .rd_bot    (rd_bot),
        .rd_x      (rd_x),
        .rd_y      (rd_y),
        .rd_data   (mem_rdata),
        .x_last    (w_q - DIM_W'(1)),
        .y_last    (h_q - DIM_W'(2)),
        .take      (take),
        .col_full  (col_full),
        .col       (col),
        .col_x     (col_x),
        .col_y     (col_y),
        .col_first (col_first),
        .col_last  (col_last)
    );

    swin_winout #(.DIM_W(DIM_W)) u_winout (
        .clk         (clk),
        .rst         (rst),
        .col_full    (col_full),
        .col         (col),
        .col_x       (col_x),
        .col_y       (col_y),
        .col_first   (col_first),
        .col_last    (col_last),
        .take        (take),
        .win_ready   (win_ready),
        .win_valid   (win_valid),
        .win_px      (win_px),
        .win_x       (win_x),
        .win_y       (win_y),
        .last_accept (last_accept)
    );

    assign win_tl = win_px.tl;
    assign win_tr = win_px.tr;
    assign win_bl = win_px.bl;
    assign win_br = win_px.br;

    // R10: the memory port is quiet whenever no frame is running
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !running |-> !mem_req);

    // R10: done only rises right after an accepted window
    assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(win_valid && win_ready));

    // R2: every address lies inside the image
    assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (32'(mem_addr) < 32'(w_q) * 32'(h_q)));

    // R3: presented coordinates stay inside the window grid
    assert_coord_range_R3: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (win_x <= w_q - DIM_W'(2) && win_y <= h_q - DIM_W'(2)));

endmodule

// File: tb/swin_reuse_buf_test.sv
module swin_reuse_buf_test;

    localparam int DW = 6;
    localparam int AW = 12;

    typedef struct {
        int x;
        int y;
        int tl;
        int tr;
        int bl;
        int br;
    } exp_win_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] img_w = '0;
    logic [DW-1:0] img_h = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata = '0;
    logic          win_valid;
    logic          win_ready = 1'b0;
    logic [15:0]   win_tl, win_tr, win_bl, win_br;
    logic [DW-1:0] win_x, win_y;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int reads  = 0;
    int cur_w  = 2;
    int cur_h  = 2;
    int mode   = 0;
    int last_acc_cyc = 0;
    bit expect_done = 1'b0;
    bit held = 1'b0;
    logic [15:0] h_tl, h_tr, h_bl, h_br;
    logic [DW-1:0] h_x, h_y;
    exp_win_t exp_q[$];

    always #10 clk = ~clk;

    swin_reuse_buf #(.DIM_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .img_w(img_w), .img_h(img_h),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .win_valid(win_valid), .win_ready(win_ready),
        .win_tl(win_tl), .win_tr(win_tr), .win_bl(win_bl), .win_br(win_br),
        .win_x(win_x), .win_y(win_y), .done(done)
    );

    function automatic logic [15:0] pixf(input int a);
        int v;
        v = a * 40503 + 1234;
        return v[15:0] ^ 16'(a >> 2);
    endfunction

    task automatic chk(input bit ok, input string tag, input string detail);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= pixf(int'(mem_addr));
    end

    // reference comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (expect_done) begin
                chk(done == 1'b1, "R10", $sformatf("done got %0b exp 1", done));
                expect_done = 1'b0;
            end
            if (mem_req) begin
                reads++;
                chk(int'(mem_addr) < cur_w * cur_h, "R2",
                    $sformatf("addr got %0d exp below %0d", mem_addr, cur_w * cur_h));
            end
            if (held) begin
                chk(win_valid && win_tl == h_tl && win_tr == h_tr && win_bl == h_bl &&
                    win_br == h_br && win_x == h_x && win_y == h_y, "R8",
                    $sformatf("held window changed: x %0d/%0d y %0d/%0d", win_x, h_x, win_y, h_y));
            end
            if (win_valid && win_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", $sformatf("extra window x %0d y %0d exp none", win_x, win_y));
                end else begin
                    exp_win_t e;
                    e = exp_q.pop_front();
                    chk(int'(win_x) == e.x && int'(win_y) == e.y, "R4",
                        $sformatf("coord got (%0d,%0d) exp (%0d,%0d)", win_x, win_y, e.x, e.y));
                    chk(int'(win_tl) == e.tl && int'(win_tr) == e.tr &&
                        int'(win_bl) == e.bl && int'(win_br) == e.br, "R3",
                        $sformatf("pixels got %h %h %h %h exp %h %h %h %h", win_tl, win_tr,
                                  win_bl, win_br, e.tl, e.tr, e.bl, e.br));
                    if (e.x == 0) begin
                        chk(reads >= 2 * cur_w * e.y + 4, "R6",
                            $sformatf("reads before row start got %0d exp at least %0d",
                                      reads, 2 * cur_w * e.y + 4));
                    end else if (mode == 0) begin
                        chk(cyc - last_acc_cyc == 2, "R7",
                            $sformatf("window spacing got %0d exp 2", cyc - last_acc_cyc));
                    end
                    if (exp_q.size() == 0) expect_done = 1'b1;
                    else chk(done == 1'b0, "R10", $sformatf("done got %0b exp 0", done));
                end
                last_acc_cyc = cyc;
            end
            held = win_valid && !win_ready;
            h_tl = win_tl; h_tr = win_tr; h_bl = win_bl; h_br = win_br;
            h_x = win_x; h_y = win_y;
        end
    end

    task automatic run_frame(input int w, input int h, input int m);
        logic [15:0] lfsr;
        int r20;
        bit finished;
        lfsr = 16'hACE1;
        r20 = 0;
        finished = 1'b0;
        exp_q.delete();
        for (int y = 0; y < h - 1; y++) begin
            for (int x = 0; x < w - 1; x++) begin
                exp_win_t e;
                e.x = x; e.y = y;
                e.tl = int'(pixf(y * w + x));
                e.tr = int'(pixf(y * w + x + 1));
                e.bl = int'(pixf((y + 1) * w + x));
                e.br = int'(pixf((y + 1) * w + x + 1));
                exp_q.push_back(e);
            end
        end
        @(posedge clk); #2;
        cur_w = w; cur_h = h; mode = m; reads = 0;
        img_w = DW'(w); img_h = DW'(h); start = 1'b1;
        win_ready = (m == 0);
        @(posedge clk); #2;
        start = 1'b0;
        for (int c = 0; c < 4000 && !finished; c++) begin
            if (m == 1) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                win_ready = lfsr[0] | lfsr[1];
                // R11: a start in mid-frame with other dimensions must be ignored
                if (c == 6) begin
                    start = 1'b1; img_w = DW'(w + 1); img_h = DW'(h + 1);
                end else begin
                    start = 1'b0;
                end
            end else if (m == 2) begin
                win_ready = (c >= 40);
                if (c == 20) r20 = reads;
                if (c == 39) begin
                    chk(reads == r20 && reads <= 8 && reads >= 4, "R9",
                        $sformatf("reads under stall got %0d (at c20 %0d) exp steady, 4..8", reads, r20));
                end
            end else begin
                win_ready = 1'b1;
            end
            @(posedge clk); #2;
            if (done) finished = 1'b1;
        end
        start = 1'b0;
        chk(finished, "R10", $sformatf("frame %0dx%0d done got 0 exp 1", w, h));
        chk(exp_q.size() == 0, "R4", $sformatf("windows missing got %0d exp 0", exp_q.size()));
        chk(reads == 2 * w * (h - 1), "R5",
            $sformatf("read count got %0d exp %0d", reads, 2 * w * (h - 1)));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(done && !mem_req && !win_valid, "R10",
                $sformatf("idle got done %0b req %0b valid %0b exp 1 0 0", done, mem_req, win_valid));
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(!win_valid && !mem_req && !done, "R1",
            $sformatf("reset got valid %0b req %0b done %0b exp 0 0 0", win_valid, mem_req, done));
        run_frame(5, 3, 0);
        run_frame(2, 2, 0);
        run_frame(4, 4, 1);
        run_frame(6, 3, 2);
        run_frame(7, 2, 1);
        run_frame(3, 5, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run got hung exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule